// File: doc/BRIEF.md
# Chained DMA Channel Controller

This block is one bus-master DMA channel. Software programs it through three 32-bit registers, one for control and status, one for the transfer address and one for the byte count. Each descriptor is an address plus a byte count. The channel holds two descriptors: an active one that it is working on now, and a next one that software may stage while the active one runs. When the active descriptor reaches terminal count, a staged descriptor takes its place in the same cycle, so the bursts carry on without a gap.

The channel splits the active descriptor into memory bursts of a programmed word length. Each burst goes out as one request on a valid/ready request port. The channel holds the request steady until the memory port accepts it, and never has more than one burst outstanding. One response pulse completes the burst, and the pulse carries an error flag. The channel reports terminal count, device events and memory errors through sticky pending bits that are cleared by writing one, and it drives a single interrupt line.

A soft reset command abandons the work in progress. While a burst that was already accepted is still in flight, the status register shows it as draining.

Top module: `dma_chain_chan`

## Requirements
- R1: After reset, the control/status register (byte offset 0x0), the address register (0x4) and the count register (0x8) all read zero, and no request or interrupt is driven.
- R2: A write to 0x8 sets the staged count; only bits 23:0 are kept. A later write to 0x4 sets the staged address and marks the next descriptor loaded (status bit 27). While bit 27 is set, writes to 0x4 and 0x8 are ignored.
- R3: The next descriptor moves to active only while enable-next (bit 24) is 1. It moves when the active slot is empty, or in the same cycle that the active descriptor reaches terminal count. A move sets active-loaded (bit 26) and clears bit 27.
- R4: The burst field (bits 19:18) encodes 00=4, 01=8, 10=1 and 11=16 words. A request carries min(burst, remaining) bytes, rounded up to whole words. Each completed burst advances the address by 4 bytes per word and lowers the count by the bytes it carried.
- R5: Reading 0x4 returns the live active address, and reading 0x8 returns the live remaining byte count.
- R6: At terminal count, the terminal-count bit (14) is set. Interrupt-pending (bit 0) is also set, unless the terminal-count interrupt disable bit (23) is 1.
- R7: A pulse on dev_irq sets bit 0 and leaves bit 14 unchanged.
- R8: Writing the control register with bit 0 set clears bits 0 and 14. Writing it with bit 1 set clears bit 1. Writing a 0 in these positions leaves them unchanged.
- R9: irq is high exactly when interrupt-enable (bit 4) is 1 and bit 0 or bit 1 is 1.
- R10: An error response sets error-pending (bit 1) and does not set bit 14. It leaves the address and count unchanged and stops further requests. Bit 25 (channel on) reads 0.
- R11: Writing bit 7 clears all control bits, pending bits and descriptors. If a burst is in flight, bits 2 (draining) and 10 (cycle pending) stay set until its response arrives, and that response is ignored.
- R12: Requests are issued only when DMA-enable (bit 9), count-enable (bit 13) and bit 26 are all 1. mem_req_write follows direction bit 8. While mem_req_valid is high and mem_req_ready is low, the request fields hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dev_irq | input | 1 | Device event pulse |
| irq | output | 1 | Interrupt request |
| mem_req_valid | output | 1 | Burst request valid |
| mem_req_ready | input | 1 | Burst request accepted |
| mem_req_addr | output | AW | Burst start byte address |
| mem_req_len | output | 5 | Burst length in words |
| mem_req_write | output | 1 | Burst direction (1 = write to memory) |
| mem_rsp_valid | input | 1 | Burst completion pulse |
| mem_rsp_err | input | 1 | Completion carries an error |

## Verification
The bench runs the main countdown over a table of burst codes and lengths. The lengths include exact multiples of the burst, a short tail, a sub-word length and a single burst, so the request count, the tail length and the final address separate a wrong code decode from wrong rounding or wrong tail shortening. Descriptor staging is tried with a parked next descriptor, a refused third load and an immediate chain. Two different lengths are used there, so a write that should have been refused shows up in the issued addresses. A burst held back by ready low, an error response, and a soft reset with a burst still in flight each isolate the holding, stopping and draining behaviour.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int LEN_W = 5;
  localparam int B_INT_PEND = 0;
  localparam int B_ERR_PEND = 1;
  localparam int B_DRAIN    = 2;
  localparam int B_INT_EN   = 4;
  localparam int B_SRST     = 7;
  localparam int B_WDIR     = 8;
  localparam int B_DMA_EN   = 9;
  localparam int B_CYC      = 10;
  localparam int B_CNT_EN   = 13;
  localparam int B_TC       = 14;
  localparam int B_BURST    = 18;
  localparam int B_TCI_DIS  = 23;
  localparam int B_EN_NEXT  = 24;
  localparam int B_ON       = 25;
  localparam int B_ACT      = 26;
  localparam int B_NXT      = 27;

  typedef enum logic [1:0] {
    BURST_W4  = 2'b00,
    BURST_W8  = 2'b01,
    BURST_W1  = 2'b10,
    BURST_W16 = 2'b11
  } burst_e;

  typedef struct packed {
    logic   int_en;
    logic   wdir;
    logic   dma_en;
    logic   cnt_en;
    logic   tci_dis;
    logic   en_next;
    burst_e burst;
  } ctl_t;

  function automatic logic [LEN_W-1:0] burst_words(input burst_e b);
    case (b)
      BURST_W8:  return LEN_W'(8);
      BURST_W1:  return LEN_W'(1);
      BURST_W16: return LEN_W'(16);
      default:   return LEN_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_chain_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic [31:0] csr_wdata,
  input  logic        tc_pulse,
  input  logic        err_pulse,
  input  logic        dev_irq,
  output ctl_t        ctl,
  output logic        soft_rst,
  output logic        int_pend,
  output logic        err_pend,
  output logic        tc_flag,
  output logic        irq
);
  logic unused_wbits;
  assign unused_wbits = ^{csr_wdata[31:25], csr_wdata[22:20], csr_wdata[17:15],
                          csr_wdata[12:10], csr_wdata[6:5], csr_wdata[3:2]};

  assign soft_rst = csr_we && csr_wdata[B_SRST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl      <= '0;
      int_pend <= 1'b0;
      err_pend <= 1'b0;
      tc_flag  <= 1'b0;
    end else if (soft_rst) begin
      ctl      <= '0;
      int_pend <= 1'b0;
      err_pend <= 1'b0;
      tc_flag  <= 1'b0;
    end else begin
      if (csr_we) begin
        ctl.int_en  <= csr_wdata[B_INT_EN];
        ctl.wdir    <= csr_wdata[B_WDIR];
        ctl.dma_en  <= csr_wdata[B_DMA_EN];
        ctl.cnt_en  <= csr_wdata[B_CNT_EN];
        ctl.tci_dis <= csr_wdata[B_TCI_DIS];
        ctl.en_next <= csr_wdata[B_EN_NEXT];
        ctl.burst   <= burst_e'(csr_wdata[B_BURST+1:B_BURST]);
        if (csr_wdata[B_INT_PEND]) begin
          int_pend <= 1'b0;
          tc_flag  <= 1'b0;
        end
        if (csr_wdata[B_ERR_PEND]) err_pend <= 1'b0;
      end
      // new events win over a clear in the same cycle
      if (tc_pulse) begin
        tc_flag <= 1'b1;
        if (!ctl.tci_dis) int_pend <= 1'b1;
      end
      if (dev_irq)   int_pend <= 1'b1;
      if (err_pulse) err_pend <= 1'b1;
    end
  end

  assign irq = ctl.int_en && (int_pend || err_pend);
endmodule

// File: rtl/dma_desc_pair.sv
module dma_desc_pair
  import dma_chain_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             addr_we,
  input  logic             cnt_we,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CW-1:0]    wr_cnt,
  input  logic             en_next,
  input  logic             step_valid,
  input  logic [CW-1:0]    step_bytes,
  input  logic [LEN_W-1:0] step_words,
  output logic [AW-1:0]    act_addr,
  output logic [CW-1:0]    act_cnt,
  output logic             act_loaded,
  output logic             nxt_loaded,
  output logic             tc_pulse
);
  logic [AW-1:0] nxt_addr;
  logic [CW-1:0] nxt_cnt;
  logic          promote;

  assign tc_pulse = step_valid && (step_bytes >= act_cnt);
  assign promote  = nxt_loaded && en_next && (!act_loaded || tc_pulse);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_addr   <= '0;
      act_cnt    <= '0;
      act_loaded <= 1'b0;
      nxt_addr   <= '0;
      nxt_cnt    <= '0;
      nxt_loaded <= 1'b0;
    end else if (soft_rst) begin
      act_addr   <= '0;
      act_cnt    <= '0;
      act_loaded <= 1'b0;
      nxt_addr   <= '0;
      nxt_cnt    <= '0;
      nxt_loaded <= 1'b0;
    end else begin
      if (cnt_we && !nxt_loaded) nxt_cnt <= wr_cnt;
      if (addr_we && !nxt_loaded) begin
        nxt_addr   <= wr_addr;
        nxt_loaded <= 1'b1;
      end
      if (step_valid) begin
        act_addr <= act_addr + AW'({step_words, 2'b00});
        act_cnt  <= act_cnt - step_bytes;
        if (tc_pulse) act_loaded <= 1'b0;
      end
      if (promote) begin
        act_addr   <= nxt_addr;
        act_cnt    <= nxt_cnt;
        act_loaded <= 1'b1;
        nxt_loaded <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
  import dma_chain_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             run,
  input  logic [AW-1:0]    act_addr,
  input  logic [CW-1:0]    act_cnt,
  input  burst_e           burst,
  input  logic             wdir,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_addr,
  output logic [LEN_W-1:0] mem_req_len,
  output logic             mem_req_write,
  input  logic             mem_rsp_valid,
  input  logic             mem_rsp_err,
  output logic             step_valid,
  output logic [CW-1:0]    step_bytes,
  output logic [LEN_W-1:0] step_words,
  output logic             err_pulse,
  output logic             cyc_pend,
  output logic             draining
);
  logic             vld_q, outst_q, drain_q, wr_q;
  logic [AW-1:0]    addr_q;
  logic [LEN_W-1:0] len_q;
  logic [CW-1:0]    bytes_q;
  logic [CW-1:0]    bb_bytes, cut_bytes;
  logic [LEN_W-1:0] cut_words;
  logic             issue, rsp_take;

  assign bb_bytes  = CW'({burst_words(burst), 2'b00});
  assign cut_bytes = (act_cnt < bb_bytes) ? act_cnt : bb_bytes;
  assign cut_words = LEN_W'((cut_bytes + CW'(3)) >> 2);
  assign issue     = run && !soft_rst && !vld_q && !outst_q && (act_cnt != '0);
  assign rsp_take  = outst_q && mem_rsp_valid && !drain_q && !soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      outst_q <= 1'b0;
      drain_q <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      len_q   <= '0;
      bytes_q <= '0;
    end else begin
      if (issue) begin
        vld_q   <= 1'b1;
        addr_q  <= act_addr;
        len_q   <= cut_words;
        bytes_q <= cut_bytes;
        wr_q    <= wdir;
      end
      if (vld_q && mem_req_ready) begin
        vld_q   <= 1'b0;
        outst_q <= 1'b1;
      end
      if (outst_q && mem_rsp_valid) outst_q <= 1'b0;
      if (soft_rst && (vld_q || outst_q)) drain_q <= 1'b1;
      else if (!(vld_q || outst_q))       drain_q <= 1'b0;
    end
  end

  assign mem_req_valid = vld_q;
  assign mem_req_addr  = addr_q;
  assign mem_req_len   = len_q;
  assign mem_req_write = wr_q;
  assign step_valid    = rsp_take && !mem_rsp_err;
  assign err_pulse     = rsp_take && mem_rsp_err;
  assign step_bytes    = bytes_q;
  assign step_words    = len_q;
  assign cyc_pend      = vld_q || outst_q;
  assign draining      = drain_q;
endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
  import dma_chain_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             dev_irq,
  output logic             irq,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_addr,
  output logic [LEN_W-1:0] mem_req_len,
  output logic             mem_req_write,
  input  logic             mem_rsp_valid,
  input  logic             mem_rsp_err
);
  localparam logic [1:0] SEL_CSR = 2'd0;
  localparam logic [1:0] SEL_ADR = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;

  ctl_t             ctl;
  logic             soft_rst, int_pend, err_pend, tc_flag;
  logic             csr_we, addr_we, cnt_we;
  logic [AW-1:0]    act_addr;
  logic [CW-1:0]    act_cnt;
  logic             act_loaded, nxt_loaded, tc_pulse;
  logic             step_valid, err_pulse, cyc_pend, draining, dma_on;
  logic [CW-1:0]    step_bytes;
  logic [LEN_W-1:0] step_words;
  logic             int_en, en_next;
  logic             unused_abits;

  assign unused_abits = ^reg_addr[1:0];
  assign csr_we  = reg_we && (reg_addr[3:2] == SEL_CSR);
  assign addr_we = reg_we && (reg_addr[3:2] == SEL_ADR);
  assign cnt_we  = reg_we && (reg_addr[3:2] == SEL_CNT);
  assign dma_on  = ctl.dma_en && ctl.cnt_en && act_loaded && !err_pend && !draining;
  assign int_en  = ctl.int_en;
  assign en_next = ctl.en_next;

  dma_ctl_regs u_ctl (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(reg_wdata),
    .tc_pulse(tc_pulse), .err_pulse(err_pulse), .dev_irq(dev_irq),
    .ctl(ctl), .soft_rst(soft_rst), .int_pend(int_pend), .err_pend(err_pend),
    .tc_flag(tc_flag), .irq(irq)
  );

  dma_desc_pair #(.AW(AW), .CW(CW)) u_desc (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .addr_we(addr_we), .cnt_we(cnt_we),
    .wr_addr(reg_wdata[AW-1:0]), .wr_cnt(reg_wdata[CW-1:0]), .en_next(ctl.en_next),
    .step_valid(step_valid), .step_bytes(step_bytes), .step_words(step_words),
    .act_addr(act_addr), .act_cnt(act_cnt), .act_loaded(act_loaded),
    .nxt_loaded(nxt_loaded), .tc_pulse(tc_pulse)
  );

  dma_burst_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .run(dma_on),
    .act_addr(act_addr), .act_cnt(act_cnt), .burst(ctl.burst), .wdir(ctl.wdir),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len), .mem_req_write(mem_req_write),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
    .step_valid(step_valid), .step_bytes(step_bytes), .step_words(step_words),
    .err_pulse(err_pulse), .cyc_pend(cyc_pend), .draining(draining)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr[3:2])
      SEL_CSR: begin
        reg_rdata[B_INT_PEND]          = int_pend;
        reg_rdata[B_ERR_PEND]          = err_pend;
        reg_rdata[B_DRAIN]             = draining;
        reg_rdata[B_INT_EN]            = ctl.int_en;
        reg_rdata[B_WDIR]              = ctl.wdir;
        reg_rdata[B_DMA_EN]            = ctl.dma_en;
        reg_rdata[B_CYC]               = cyc_pend;
        reg_rdata[B_CNT_EN]            = ctl.cnt_en;
        reg_rdata[B_TC]                = tc_flag;
        reg_rdata[B_BURST+1:B_BURST]   = ctl.burst;
        reg_rdata[B_TCI_DIS]           = ctl.tci_dis;
        reg_rdata[B_EN_NEXT]           = ctl.en_next;
        reg_rdata[B_ON]                = dma_on;
        reg_rdata[B_ACT]               = act_loaded;
        reg_rdata[B_NXT]               = nxt_loaded;
      end
      SEL_ADR: reg_rdata = 32'(act_addr);
      SEL_CNT: reg_rdata = 32'(act_cnt);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic [4:0]    mem_req_len,
  input logic          irq,
  input logic          int_en,
  input logic          err_pend,
  input logic          tc_pulse,
  input logic          en_next,
  input logic          act_loaded,
  input logic          nxt_loaded,
  input logic          draining,
  input logic          cyc_pend
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_len)); // R12
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_len != 5'd0) && (mem_req_len <= 5'd16)); // R4
  AST_CHAIN_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse && en_next && nxt_loaded |=> act_loaded && !nxt_loaded); // R3
  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    err_pend && !mem_req_valid |=> !mem_req_valid); // R10
  AST_DRAIN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    draining && !cyc_pend |=> !draining); // R11
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> !irq); // R9
endmodule

bind dma_chain_chan dma_chain_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len), .irq(irq), .int_en(int_en),
  .err_pend(err_pend), .tc_pulse(tc_pulse), .en_next(en_next), .act_loaded(act_loaded),
  .nxt_loaded(nxt_loaded), .draining(draining), .cyc_pend(cyc_pend)
);

// File: tb/sim_dma_chain_chan.sv
`timescale 1ns/1ps
module sim_dma_chain_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dev_irq = 1'b0;
  logic        irq;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic [4:0]  mem_req_len;
  logic        mem_req_write;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_err = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int lat = 2;
  bit err_next = 1'b0;
  bit mem_hold = 1'b0;
  int req_count = 0;
  logic [31:0] first_addr, last_addr;
  logic [4:0]  last_len;

  localparam logic [31:0] RUN = (32'd1 << 4) | (32'd1 << 9) | (32'd1 << 13) | (32'd1 << 24);

  typedef struct packed {
    logic [1:0]  burst;
    logic [23:0] len;
    logic [7:0]  reqs;
    logic [4:0]  last;
    logic [15:0] endoff;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{2'b00, 24'd16,  8'd1, 5'd4,  16'd16},
    '{2'b00, 24'd20,  8'd2, 5'd1,  16'd20},
    '{2'b01, 24'd100, 8'd4, 5'd1,  16'd100},
    '{2'b10, 24'd12,  8'd3, 5'd1,  16'd12},
    '{2'b11, 24'd64,  8'd1, 5'd16, 16'd64},
    '{2'b11, 24'd70,  8'd2, 5'd2,  16'd72},
    '{2'b01, 24'd3,   8'd1, 5'd1,  16'd4}
  };

  dma_chain_chan u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_irq(dev_irq), .irq(irq),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len), .mem_req_write(mem_req_write),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err)
  );

  initial forever #4 clk = ~clk;

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog R1..all actual=%0d expected<150000", cycles);
        finish_run();
      end
    end
  end

  // memory port model: accepts on ready, answers after lat cycles
  initial begin
    bit pend = 1'b0;
    int wait_n = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_err = 1'b0;
      mem_req_ready = !mem_hold;
      if (pend) begin
        if (wait_n == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_err = err_next;
          err_next = 1'b0;
          pend = 1'b0;
        end else wait_n--;
      end else if (mem_req_valid && mem_req_ready) begin
        if (req_count == 0) first_addr = mem_req_addr;
        last_addr = mem_req_addr;
        last_len = mem_req_len;
        req_count++;
        pend = 1'b1;
        wait_n = lat;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%h expected=0x%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic soft_reset();
    wr(4'h0, 32'd1 << 7);
    idle(2);
    req_count = 0;
  endtask

  task automatic wait_csr(input int bitn);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(4'h0, v);
      if (v[bitn]) break;
    end
  endtask

  task automatic wait_reqs(input int n);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      #1;
      if (req_count >= n) break;
    end
  endtask

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(4'h0, v); check("R1 csr after reset", v, 32'h0);
    rd(4'h4, v); check("R1 addr after reset", v, 32'h0);
    rd(4'h8, v); check("R1 count after reset", v, 32'h0);
    check("R1 irq after reset", {31'd0, irq}, 32'h0);
    check("R1 no request after reset", {31'd0, mem_req_valid}, 32'h0);

    // table: burst codes and lengths, R4 R6 R5
    for (int i = 0; i < 7; i++) begin
      soft_reset();
      wr(4'h0, RUN | (32'(VEC[i].burst) << 18));
      wr(4'h8, 32'(VEC[i].len));
      wr(4'h4, 32'h1000);
      wait_csr(14);
      idle(3);
      check("R4 request count", 32'(req_count), 32'(VEC[i].reqs));
      check("R4 tail length", 32'(last_len), 32'(VEC[i].last));
      check("R4 first address", first_addr, 32'h1000);
      rd(4'h4, v); check("R5 final address", v, 32'h1000 + 32'(VEC[i].endoff));
      rd(4'h8, v); check("R5 residue zero", v, 32'h0);
      rd(4'h0, v); check("R6 tc and pending", v & 32'h0C00_4003, 32'h0000_4001);
      check("R9 irq on tc", {31'd0, irq}, 32'h1);
    end

    // R2 R3 parking, refusal and chaining
    soft_reset();
    wr(4'h0, (32'd1 << 4) | (32'd1 << 13) | (32'd3 << 18));
    wr(4'h8, 32'd16);
    wr(4'h4, 32'h100);
    rd(4'h0, v); check("R3 parked without enable-next", v & 32'h0C00_0000, 32'h0800_0000);
    wr(4'h8, 32'd32);
    wr(4'h4, 32'h200);
    wr(4'h0, (32'd1 << 4) | (32'd1 << 13) | (32'd3 << 18) | (32'd1 << 24));
    rd(4'h0, v); check("R3 promoted into empty slot", v & 32'h0C00_0000, 32'h0400_0000);
    rd(4'h8, v); check("R2 count write refused while loaded", v, 32'd16);
    rd(4'h4, v); check("R5 active address", v, 32'h100);
    wr(4'h8, 32'd32);
    wr(4'h4, 32'h200);
    wr(4'h8, 32'd8);
    wr(4'h4, 32'h300);
    rd(4'h0, v); check("R2 next loaded flag", {31'd0, v[27]}, 32'h1);
    req_count = 0;
    wr(4'h0, RUN | (32'd3 << 18));
    idle(40);
    check("R3 chained request count", 32'(req_count), 32'd2);
    check("R3 first descriptor start", first_addr, 32'h100);
    check("R2 refused address not used", last_addr, 32'h200);
    check("R2 refused count not used", 32'(last_len), 32'd8);
    rd(4'h4, v); check("R3 address after chain", v, 32'h220);
    rd(4'h0, v); check("R3 both slots empty", v & 32'h0C00_4000, 32'h0000_4000);

    // R5 live residue mid-transfer
    soft_reset();
    lat = 6;
    wr(4'h0, RUN);
    wr(4'h8, 32'd40);
    wr(4'h4, 32'h2000);
    wait_reqs(2);
    rd(4'h8, v); check("R5 live residue", v, 32'd24);
    rd(4'h4, v); check("R5 live address", v, 32'h2010);
    lat = 2;
    wait_csr(14);

    // R6 terminal-count interrupt disable
    soft_reset();
    wr(4'h0, RUN | (32'd3 << 18) | (32'd1 << 23));
    wr(4'h8, 32'd8);
    wr(4'h4, 32'h40);
    idle(30);
    rd(4'h0, v); check("R6 tc without pending", v & 32'h0000_4001, 32'h0000_4000);
    check("R6 irq stays low", {31'd0, irq}, 32'h0);

    // R8 clear, R7 device event, R9 gating
    wr(4'h0, RUN | (32'd1 << 23) | 32'd1);
    rd(4'h0, v); check("R8 write-one clears tc", {31'd0, v[14]}, 32'h0);
    @(negedge clk); dev_irq = 1'b1;
    @(negedge clk); dev_irq = 1'b0;
    rd(4'h0, v); check("R7 device sets pending only", v & 32'h0000_4001, 32'h0000_0001);
    check("R9 irq on device event", {31'd0, irq}, 32'h1);
    wr(4'h0, RUN & ~(32'd1 << 4));
    check("R9 irq masked", {31'd0, irq}, 32'h0);
    rd(4'h0, v); check("R8 zero write keeps pending", {31'd0, v[0]}, 32'h1);
    wr(4'h0, 32'd1);
    rd(4'h0, v); check("R8 write-one clears pending", {31'd0, v[0]}, 32'h0);

    // R10 error response
    soft_reset();
    err_next = 1'b1;
    wr(4'h0, RUN);
    wr(4'h8, 32'd32);
    wr(4'h4, 32'h3000);
    idle(30);
    check("R10 single request", 32'(req_count), 32'd1);
    rd(4'h0, v); check("R10 error pending, no tc, off", v & 32'h0200_4003, 32'h0000_0002);
    rd(4'h8, v); check("R10 count unchanged", v, 32'd32);
    rd(4'h4, v); check("R10 address unchanged", v, 32'h3000);
    check("R9 irq on error", {31'd0, irq}, 32'h1);
    wr(4'h0, 32'd2);
    rd(4'h0, v); check("R8 error cleared by write-one", v, 32'h0400_0000);

    // R11 soft reset with a burst in flight
    soft_reset();
    lat = 40;
    wr(4'h0, RUN | (32'd3 << 18));
    wr(4'h8, 32'd64);
    wr(4'h4, 32'h4000);
    wait_reqs(1);
    idle(2);
    wr(4'h0, 32'd1 << 7);
    rd(4'h0, v); check("R11 draining and cycle pending", v, 32'h0000_0404);
    rd(4'h8, v); check("R11 count cleared", v, 32'h0);
    idle(60);
    rd(4'h0, v); check("R11 drain finished", v, 32'h0);
    check("R11 no further request", 32'(req_count), 32'd1);
    lat = 2;

    // R12 held request and direction
    soft_reset();
    mem_hold = 1'b1;
    wr(4'h0, RUN | (32'd1 << 18) | (32'd1 << 8));
    wr(4'h8, 32'd16);
    wr(4'h4, 32'h5000);
    idle(5);
    check("R12 request held valid", {31'd0, mem_req_valid}, 32'h1);
    check("R12 held address", mem_req_addr, 32'h5000);
    check("R12 write direction", {31'd0, mem_req_write}, 32'h1);
    check("R12 not taken while not ready", 32'(req_count), 32'd0);
    mem_hold = 1'b0;
    idle(20);
    rd(4'h0, v); check("R12 completes after ready", {31'd0, v[14]}, 32'h1);

    // R12 count-enable gating, R2 count width
    soft_reset();
    wr(4'h0, (32'd1 << 9) | (32'd1 << 24));
    wr(4'h8, 32'hFF00_0010);
    wr(4'h4, 32'h6000);
    idle(10);
    check("R12 no request without count enable", 32'(req_count), 32'd0);
    rd(4'h0, v); check("R12 loaded but off", v & 32'h0600_0000, 32'h0400_0000);
    rd(4'h8, v); check("R2 count masked to 24 bits", v, 32'h10);

    finish_run();
  end
endmodule